// File: doc/BRIEF.md
# I2C Transaction Command Compiler

This block turns a list of I2C message descriptors into the compact line-command program that a separate bit-level I2C sequencer runs. Every message gives a 7-bit target address, a direction flag, a byte count and, when writing, its payload bytes. The compiler reads the descriptors through a small indexed read port. It expands each message into one 4-bit command per bus action, packs pairs of commands into bytes, and writes those bytes into the command memory starting at byte 0. When it finishes it reports the number of commands it produced.

A compile run starts with a one-cycle `start` pulse and the message count. The block first scans every descriptor. If any descriptor asks for a length-prefixed (receive-length) read, the block refuses the whole list and writes nothing. Otherwise it emits, in order: for each message a start condition, the address byte and the data phase. After the last message it emits one stop condition, then the end marker, plus a second end marker when that is needed to make the count even. `done` rises after the final byte write and stays high until the next accepted start.

Command codes: end 0x0, clock low 0x2, clock high 0x3, data low 0x4, data high 0x5, send-0 0x8, send-1 0xC, sample 0xD, check-ack-0 0xE.

Top module: `i2c_cmd_encoder`

## Requirements
- R1: Each message begins with the four commands 0x5, 0x3, 0x4, 0x2, in that order.
- R2: After the start commands comes the address byte {addr[6:0], rd}, sent MSB first as 0xC for a 1 bit and 0x8 for a 0 bit, then 0xE.
- R3: In a write message, each payload byte is sent MSB first, one command per bit (0xC for 1, 0x8 for 0), and is followed by 0xE.
- R4: In a read message, each byte is eight 0xD commands followed by 0x8. The final byte of the message ends with 0xC instead of 0x8.
- R5: The commands 0x4, 0x3, 0x5 appear exactly once, after the final message only.
- R6: The stream ends with 0x0, and with a second 0x0 when the count would otherwise be odd, so `cmd_count` at `done` is always even.
- R7: Commands are packed two per byte, the earlier one in bits [3:0]. Bytes are written to consecutive addresses starting at 0. `cmd_count` equals twice the number of bytes written.
- R8: If any descriptor has `msg_rxlen` set, `err` rises with `done`, no memory write occurs and `cmd_count` is 0.
- R9: A start with `msg_num` = 0 raises `done` with `err` low, no memory write and `cmd_count` 0.
- R10: After reset, `done`, `busy`, `mem_we` and `cmd_count` are 0. `done` rises only after the last write strobe has dropped, and it stays high until the next accepted start.
- R11: A `start` pulse while `busy` is high has no effect on the stream being produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin compiling a list (accepted when not busy) |
| msg_num | input | MSG_W+1 | Number of messages in the list |
| msg_idx | output | MSG_W | Index of the descriptor being read |
| msg_addr | input | 7 | Target address of descriptor msg_idx |
| msg_rd | input | 1 | 1 = read message |
| msg_rxlen | input | 1 | 1 = receive-length read requested (refused) |
| msg_len | input | LEN_W | Byte count of descriptor msg_idx |
| pay_idx | output | LEN_W | Index of the payload byte being read |
| pay_byte | input | 8 | Payload byte pay_idx of message msg_idx |
| mem_we | output | 1 | Command memory write strobe |
| mem_addr | output | ADDR_W | Command memory byte address |
| mem_wdata | output | 8 | Two packed commands |
| cmd_count | output | ADDR_W+1 | Commands produced in the current run |
| busy | output | 1 | Compile in progress |
| done | output | 1 | Run finished |
| err | output | 1 | List refused |

## Verification
The bench aims at the corners where a small slip changes the program the sequencer runs. A zero-length write gives an odd total and must get the padding end marker. A design that pads on the wrong parity leaves a dangling nibble or an odd count. The last byte of a read must end in data high. An encoder that acknowledges every byte would hold the target on the bus. A repeated start between messages must not bring in an early stop. A refused receive-length request placed after a valid message must leave memory untouched; a compiler that checks lazily would already have written the first message. The bench also covers the empty list and a start pulse issued mid-run. A design that restarted on that pulse would produce a corrupted, truncated stream.

// File: rtl/i2cenc_pkg.sv
package i2cenc_pkg;

  typedef enum logic [3:0] {
    LC_END    = 4'h0,
    LC_SCL_LO = 4'h2,
    LC_SCL_HI = 4'h3,
    LC_SDA_LO = 4'h4,
    LC_SDA_HI = 4'h5,
    LC_SEND0  = 4'h8,
    LC_SEND1  = 4'hC,
    LC_SAMPLE = 4'hD,
    LC_CHKACK = 4'hE
  } lcmd_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SCAN, ST_START, ST_ABYTE, ST_WBYTE, ST_RBYTE,
    ST_STOP, ST_END, ST_PAD, ST_FLUSH, ST_DONE
  } enc_st_t;

endpackage

// File: rtl/i2cenc_seq.sv
module i2cenc_seq
  import i2cenc_pkg::*;
#(
  parameter int MSG_W = 4,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [MSG_W:0]   msg_num,
  input  logic [6:0]       msg_addr,
  input  logic             msg_rd,
  input  logic             msg_rxlen,
  input  logic [LEN_W-1:0] msg_len,
  input  logic [7:0]       pay_byte,
  output logic [MSG_W-1:0] msg_idx,
  output logic [LEN_W-1:0] pay_idx,
  output logic             cmd_vld,
  output lcmd_t            cmd_nib,
  output logic             clr,
  output logic             busy,
  output logic             done,
  output logic             err
);

  typedef struct packed {
    enc_st_t          st;
    logic [MSG_W-1:0] idx;
    logic [MSG_W:0]   num;
    logic [3:0]       bitc;
    logic [LEN_W-1:0] bytei;
    logic [1:0]       sub;
    logic             par;
    logic             err;
  } seq_s;

  seq_s q, d;
  logic last_msg, last_byte, go_next;
  logic [7:0] sh_a, sh_w;

  assign last_msg  = ({1'b0, q.idx} + 1'b1) == q.num;
  assign last_byte = (q.bytei + 1'b1) == msg_len;
  assign sh_a      = {msg_addr, msg_rd} << q.bitc;
  assign sh_w      = pay_byte << q.bitc;

  assign msg_idx = q.idx;
  assign pay_idx = q.bytei;
  assign done    = (q.st == ST_DONE);
  assign busy    = (q.st != ST_IDLE) && (q.st != ST_DONE);
  assign err     = q.err;
  assign clr     = start && !busy;

  always_comb begin
    d       = q;
    cmd_vld = 1'b0;
    cmd_nib = LC_END;
    go_next = 1'b0;
    case (q.st)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          d.idx = '0;
          d.num = msg_num;
          d.err = 1'b0;
          d.par = 1'b0;
          d.st  = (msg_num == '0) ? ST_DONE : ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (msg_rxlen) begin
          d.err = 1'b1;
          d.st  = ST_DONE;
        end else if (last_msg) begin
          d.idx = '0;
          d.sub = '0;
          d.st  = ST_START;
        end else begin
          d.idx = q.idx + 1'b1;
        end
      end
      ST_START: begin
        cmd_vld = 1'b1;
        case (q.sub)
          2'd0:    cmd_nib = LC_SDA_HI;
          2'd1:    cmd_nib = LC_SCL_HI;
          2'd2:    cmd_nib = LC_SDA_LO;
          default: cmd_nib = LC_SCL_LO;
        endcase
        d.sub  = q.sub + 1'b1;
        d.bitc = '0;
        if (q.sub == 2'd3) d.st = ST_ABYTE;
      end
      ST_ABYTE: begin
        cmd_vld = 1'b1;
        if (q.bitc == 4'd8) begin
          cmd_nib = LC_CHKACK;
          d.bitc  = '0;
          d.bytei = '0;
          if (msg_len == '0) go_next = 1'b1;
          else               d.st = msg_rd ? ST_RBYTE : ST_WBYTE;
        end else begin
          cmd_nib = sh_a[7] ? LC_SEND1 : LC_SEND0;
          d.bitc  = q.bitc + 1'b1;
        end
      end
      ST_WBYTE, ST_RBYTE: begin
        cmd_vld = 1'b1;
        if (q.bitc == 4'd8) begin
          if (q.st == ST_WBYTE) cmd_nib = LC_CHKACK;
          else                  cmd_nib = last_byte ? LC_SEND1 : LC_SEND0;
          d.bitc  = '0;
          d.bytei = q.bytei + 1'b1;
          if (last_byte) go_next = 1'b1;
        end else begin
          if (q.st == ST_WBYTE) cmd_nib = sh_w[7] ? LC_SEND1 : LC_SEND0;
          else                  cmd_nib = LC_SAMPLE;
          d.bitc = q.bitc + 1'b1;
        end
      end
      ST_STOP: begin
        cmd_vld = 1'b1;
        case (q.sub)
          2'd0:    cmd_nib = LC_SDA_LO;
          2'd1:    cmd_nib = LC_SCL_HI;
          default: cmd_nib = LC_SDA_HI;
        endcase
        d.sub = q.sub + 1'b1;
        if (q.sub == 2'd2) d.st = ST_END;
      end
      ST_END: begin
        cmd_vld = 1'b1;
        d.st    = q.par ? ST_FLUSH : ST_PAD;
      end
      ST_PAD: begin
        cmd_vld = 1'b1;
        d.st    = ST_FLUSH;
      end
      ST_FLUSH: d.st = ST_DONE;
      default:  d.st = ST_IDLE;
    endcase
    if (go_next) begin
      d.sub = '0;
      if (last_msg) begin
        d.st = ST_STOP;
      end else begin
        d.idx = q.idx + 1'b1;
        d.st  = ST_START;
      end
    end
    if (cmd_vld) d.par = ~q.par;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

endmodule

// File: rtl/i2cenc_pack.sv
module i2cenc_pack
  import i2cenc_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cmd_vld,
  input  lcmd_t             cmd_nib,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic [ADDR_W:0]   cmd_count
);

  logic              half_q, half_d;
  logic [3:0]        low_q, low_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d, addr_q, addr_d;
  logic [ADDR_W:0]   cnt_q, cnt_d;
  logic              we_q, we_d;
  logic [7:0]        dat_q, dat_d;

  always_comb begin
    half_d = half_q;
    low_d  = low_q;
    ptr_d  = ptr_q;
    addr_d = addr_q;
    cnt_d  = cnt_q;
    dat_d  = dat_q;
    we_d   = 1'b0;
    if (clr) begin
      half_d = 1'b0;
      ptr_d  = '0;
      cnt_d  = '0;
    end else if (cmd_vld) begin
      cnt_d = cnt_q + 1'b1;
      if (!half_q) begin
        low_d  = cmd_nib;
        half_d = 1'b1;
      end else begin
        we_d   = 1'b1;
        dat_d  = {cmd_nib, low_q};
        addr_d = ptr_q;
        ptr_d  = ptr_q + 1'b1;
        half_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      low_q  <= '0;
      ptr_q  <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
      we_q   <= 1'b0;
      dat_q  <= '0;
    end else begin
      half_q <= half_d;
      low_q  <= low_d;
      ptr_q  <= ptr_d;
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      we_q   <= we_d;
      dat_q  <= dat_d;
    end
  end

  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = dat_q;
  assign cmd_count = cnt_q;

endmodule

// File: rtl/i2c_cmd_encoder.sv
module i2c_cmd_encoder
  import i2cenc_pkg::*;
#(
  parameter int MSG_W  = 4,
  parameter int LEN_W  = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MSG_W:0]    msg_num,
  output logic [MSG_W-1:0]  msg_idx,
  input  logic [6:0]        msg_addr,
  input  logic              msg_rd,
  input  logic              msg_rxlen,
  input  logic [LEN_W-1:0]  msg_len,
  output logic [LEN_W-1:0]  pay_idx,
  input  logic [7:0]        pay_byte,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic [ADDR_W:0]   cmd_count,
  output logic              busy,
  output logic              done,
  output logic              err
);

  logic  rst_m, rst_s;
  logic  clr, cmd_vld;
  lcmd_t cmd_nib;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  i2cenc_seq #(.MSG_W(MSG_W), .LEN_W(LEN_W)) seq_i (
    .clk(clk), .rst_n(rst_s), .start(start), .msg_num(msg_num),
    .msg_addr(msg_addr), .msg_rd(msg_rd), .msg_rxlen(msg_rxlen),
    .msg_len(msg_len), .pay_byte(pay_byte), .msg_idx(msg_idx),
    .pay_idx(pay_idx), .cmd_vld(cmd_vld), .cmd_nib(cmd_nib), .clr(clr),
    .busy(busy), .done(done), .err(err)
  );

  i2cenc_pack #(.ADDR_W(ADDR_W)) pack_i (
    .clk(clk), .rst_n(rst_s), .clr(clr), .cmd_vld(cmd_vld),
    .cmd_nib(cmd_nib), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .cmd_count(cmd_count)
  );

endmodule

// File: rtl/i2c_cmd_encoder_chk.sv
module i2c_cmd_encoder_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W:0]   cmd_count
);

  logic [ADDR_W-1:0] wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wr_n <= '0;
    else if (start && !busy)   wr_n <= '0;
    else if (mem_we)           wr_n <= wr_n + 1'b1;
  end

  // R6
  even_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd_count[0] == 1'b0));

  // R10
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_we);

  // R8
  refused_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (cmd_count == '0));

  // R7
  addr_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == wr_n));

  // R10
  done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done) && !$past(start)) |-> done);

endmodule

bind i2c_cmd_encoder i2c_cmd_encoder_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err(err), .mem_we(mem_we), .mem_addr(mem_addr), .cmd_count(cmd_count)
);

// File: tb/i2c_cmd_encoder_tb_top.sv
module i2c_cmd_encoder_tb_top;

  localparam int MSG_W = 4, LEN_W = 8, ADDR_W = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [MSG_W:0] msg_num = '0;
  logic [MSG_W-1:0] msg_idx;
  logic [LEN_W-1:0] pay_idx;
  logic [6:0] msg_addr;
  logic msg_rd, msg_rxlen;
  logic [LEN_W-1:0] msg_len;
  logic [7:0] pay_byte;
  logic mem_we, busy, done, err;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [ADDR_W:0] cmd_count;

  logic [6:0] d_addr [16];
  logic       d_rd [16];
  logic       d_rx [16];
  logic [7:0] d_len [16];
  logic [7:0] d_pay [16][16];

  logic [7:0] cap [1024];
  logic [3:0] expn [2048];
  int exp_cnt, wr_seen, checks, errors, cyc;

  always #4 clk = ~clk;

  assign msg_addr  = d_addr[msg_idx];
  assign msg_rd    = d_rd[msg_idx];
  assign msg_rxlen = d_rx[msg_idx];
  assign msg_len   = d_len[msg_idx];
  assign pay_byte  = d_pay[msg_idx][pay_idx[3:0]];

  i2c_cmd_encoder #(.MSG_W(MSG_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .msg_num(msg_num),
    .msg_idx(msg_idx), .msg_addr(msg_addr), .msg_rd(msg_rd),
    .msg_rxlen(msg_rxlen), .msg_len(msg_len), .pay_idx(pay_idx),
    .pay_byte(pay_byte), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .cmd_count(cmd_count), .busy(busy),
    .done(done), .err(err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_we) begin
      cap[mem_addr] <= mem_wdata;
      wr_seen <= wr_seen + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic add(input logic [3:0] n);
    expn[exp_cnt] = n;
    exp_cnt++;
  endtask

  task automatic build(input int num);
    logic [7:0] ab;
    exp_cnt = 0;
    for (int m = 0; m < num; m++) begin
      add(4'h5); add(4'h3); add(4'h4); add(4'h2);
      ab = {d_addr[m], d_rd[m]};
      for (int b = 7; b >= 0; b--) add(ab[b] ? 4'hC : 4'h8);
      add(4'hE);
      for (int k = 0; k < int'(d_len[m]); k++) begin
        if (d_rd[m]) begin
          for (int b = 0; b < 8; b++) add(4'hD);
          add((k == int'(d_len[m]) - 1) ? 4'hC : 4'h8);
        end else begin
          for (int b = 7; b >= 0; b--) add(d_pay[m][k][b] ? 4'hC : 4'h8);
          add(4'hE);
        end
      end
    end
    if (num > 0) begin
      add(4'h4); add(4'h3); add(4'h5); add(4'h0);
      if (exp_cnt % 2 == 1) add(4'h0);
    end
  endtask

  task automatic run(input int num, input bit poke_mid);
    int t;
    @(negedge clk);
    msg_num = (MSG_W+1)'(num);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wr_seen = 0;
    t = 0;
    while (!done && t < 4000) begin
      if (poke_mid && t == 20) begin
        msg_num = 5'd1;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      t++;
    end
    start = 1'b0;
    chk("R10 done reached", int'(done), 1);
    chk("R10 no strobe at done", int'(mem_we), 0);
  endtask

  task automatic compare(input string tag, input int num);
    build(num);
    chk({tag, " count"}, int'(cmd_count), exp_cnt);
    chk("R7 bytes written", wr_seen, exp_cnt / 2);
    chk("R8 err low", int'(err), 0);
    for (int i = 0; i < exp_cnt / 2; i++)
      chk({tag, " R7 stream byte"}, int'(cap[i]), int'({expn[2*i+1], expn[2*i]}));
  endtask

  task automatic t_reset();
    chk("R10 reset done", int'(done), 0);
    chk("R10 reset busy", int'(busy), 0);
    chk("R10 reset we", int'(mem_we), 0);
    chk("R10 reset count", int'(cmd_count), 0);
  endtask

  task automatic t_single_write();
    d_addr[0] = 7'h50; d_rd[0] = 0; d_rx[0] = 0; d_len[0] = 1; d_pay[0][0] = 8'hA5;
    run(1, 0);
    compare("R3", 1);
    chk("R1 start pair 0", int'(cap[0]), 8'h35);
    chk("R1 start pair 1", int'(cap[1]), 8'h24);
    chk("R2 addr bits 7:6", int'(cap[2]), 8'h8C);
    chk("R6 no pad count", int'(cmd_count), 26);
  endtask

  task automatic t_multi_read();
    d_addr[0] = 7'h1B; d_rd[0] = 1; d_rx[0] = 0; d_len[0] = 3;
    run(1, 0);
    compare("R4", 1);
    chk("R4 count", int'(cmd_count), 44);
  endtask

  task automatic t_combined();
    d_addr[0] = 7'h2A; d_rd[0] = 0; d_rx[0] = 0; d_len[0] = 2;
    d_pay[0][0] = 8'h0F; d_pay[0][1] = 8'h81;
    d_addr[1] = 7'h2A; d_rd[1] = 1; d_rx[1] = 0; d_len[1] = 1;
    run(2, 0);
    compare("R5 R2", 2);
  endtask

  task automatic t_zero_len();
    d_addr[0] = 7'h7F; d_rd[0] = 0; d_rx[0] = 0; d_len[0] = 0;
    run(1, 0);
    compare("R6", 1);
    chk("R6 padded count", int'(cmd_count), 18);
    chk("R6 last byte two ends", int'(cap[8]), 8'h00);
  endtask

  task automatic t_empty();
    run(0, 0);
    chk("R9 count", int'(cmd_count), 0);
    chk("R9 writes", wr_seen, 0);
    chk("R9 err", int'(err), 0);
  endtask

  task automatic t_refuse();
    d_addr[0] = 7'h10; d_rd[0] = 0; d_rx[0] = 0; d_len[0] = 1; d_pay[0][0] = 8'h33;
    d_addr[1] = 7'h11; d_rd[1] = 1; d_rx[1] = 1; d_len[1] = 2;
    run(2, 0);
    chk("R8 err", int'(err), 1);
    chk("R8 count", int'(cmd_count), 0);
    chk("R8 writes", wr_seen, 0);
    d_rx[1] = 0;
  endtask

  task automatic t_busy_start();
    d_addr[0] = 7'h44; d_rd[0] = 0; d_rx[0] = 0; d_len[0] = 2;
    d_pay[0][0] = 8'hC3; d_pay[0][1] = 8'h5A;
    d_addr[1] = 7'h45; d_rd[1] = 1; d_rx[1] = 0; d_len[1] = 2;
    run(2, 1);
    compare("R11", 2);
  endtask

  initial begin
    checks = 0; errors = 0; cyc = 0; wr_seen = 0;
    for (int i = 0; i < 16; i++) begin
      d_addr[i] = '0; d_rd[i] = 0; d_rx[i] = 0; d_len[i] = '0;
      for (int j = 0; j < 16; j++) d_pay[i][j] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_single_write();
    t_multi_read();
    t_combined();
    t_zero_len();
    t_empty();
    t_refuse();
    t_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule